// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block closes every external bus cycle of a small processor-side memory port. Once a cycle request is accepted, the block waits for one of three ending events. The first is an active-low acknowledge returned by the addressed device. The second is an internal wait-state counter that has run down. The third is a backup watchdog, the bus monitor, that fires when a cycle has lasted too long. When an event arrives, the block raises a one-bus-clock completion pulse. A companion flag on that pulse marks a watchdog ending. A sticky error bit records that such an ending happened.

The block runs on the system clock. It divides that clock by two and uses the result as the bus clock. Each bus-clock edge shows on `bus_tick`, which is high in the system cycle before that edge. Each chip select has its own configuration: an auto-acknowledge enable and a 4-bit wait-state count. The caller selects one chip select for each request. The watchdog has an enable and a 2-bit period code, shared by all chip selects. All configuration is sampled when the request is accepted and stays fixed for the rest of that cycle.

Top module: `btc_term_ctrl`

## Requirements
- R1: After reset, `done`, `done_timeout` and `err_sticky` are low.
- R2: `bus_tick` alternates every system clock, so the bus clock is half the system clock. A request is accepted on a system edge where `bus_tick` was high, the state was idle and `cyc_req` was high.
- R3: With auto-acknowledge set and wait count N (0..15), `done` rises 2*(N+1) system clocks after the accepting edge, with `done_timeout` low.
- R4: With auto-acknowledge clear, only the external acknowledge or the watchdog ends the cycle. Say `ack_n` is driven low before the bus edge at 2*j system clocks after acceptance (j >= 1). Then `done` rises 2*(j+2) clocks after acceptance, because of the two-stage synchronizer.
- R5: With auto-acknowledge set, whichever source comes first ends the cycle. The latency is 2*min(N+1, j+2).
- R6: When both sources land on the same bus edge, exactly one `done` pulse is produced.
- R7: `done` is high for exactly one bus clock (two system clocks) and changes only on bus edges.
- R8: A low pulse on `ack_n` that covers no bus edge has no effect.
- R9: Watchdog period codes 0, 1, 2 and 3 select 65536, 16384, 4096 and 1024 system clocks. With the watchdog enabled and no acknowledge, `done` rises with `done_timeout` high at period + 2 clocks after acceptance.
- R10: With the watchdog disabled, a cycle that gets no acknowledge never completes.
- R11: `err_sticky` is set by a watchdog ending and stays set until `err_clr` is pulsed. A normal ending never sets it.
- R12: The enable and the wait count are taken from the chip select given by `cs_sel`. The wait count of chip select c sits at bits [4c+3:4c] of `cfg_wait`, and its enable at bit c of `cfg_auto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_req | input | 1 | Cycle request, sampled on bus edges while idle |
| cs_sel | input | CS_W | Chip select used by the request |
| cfg_auto | input | NUM_CS | Auto-acknowledge enable, one bit per chip select |
| cfg_wait | input | 4*NUM_CS | Wait-state count, 4 bits per chip select |
| mon_en | input | 1 | Bus watchdog enable |
| mon_sel | input | 2 | Watchdog period code |
| ack_n | input | 1 | Active-low acknowledge from the device |
| err_clr | input | 1 | Clears the sticky error bit |
| bus_tick | output | 1 | High in the system cycle before each bus-clock edge |
| done | output | 1 | Cycle completion, one bus clock long |
| done_timeout | output | 1 | Qualifies `done` as a watchdog ending |
| err_sticky | output | 1 | Sticky watchdog-ending flag |

## Verification
The assertions assume a few things about the inputs. `ack_n` is released soon after a completion, so the synchronizer is clear of stale acknowledges by the time the next cycle reaches its first busy bus edge. `err_clr` is not pulsed on the same clock as a watchdog ending. The stimulus meets both. After every completion the bench releases the acknowledge and then leaves several idle bus clocks before the next request. It pulses `err_clr` only between cycles. The bench also raises every request in a cycle where `bus_tick` is high, so the accepting edge is known exactly.

// File: rtl/btc_pkg.sv
package btc_pkg;
    localparam int WS_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } btc_state_e;
endpackage

// File: rtl/btc_sync.sv
module btc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en,
    input  logic ack_n_i,
    output logic ack_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (bus_en) begin
            sync_d.s1 = ~ack_n_i;
            sync_d.s2 = sync_q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign ack_o = sync_q.s2;

    // R8: the synchronizer output moves only on bus edges
    assert_sync_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(sync_q.s2));
endmodule

// File: rtl/btc_waitgen.sv
module btc_waitgen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wg_t;

    wg_t wg_d, wg_q;

    always_comb begin
        wg_d = wg_q;
        if (load)
            wg_d.cnt = load_val;
        else if (bus_en && run && (wg_q.cnt != '0))
            wg_d.cnt = wg_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wg_q <= '0;
        else        wg_q <= wg_d;
    end

    assign zero_o = (wg_q.cnt == '0);

    // R3: once run down, the count stays at zero until the next load
    assert_zero_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load) |=> zero_o);
endmodule

// File: rtl/btc_monitor.sv
module btc_monitor #(
    parameter int MON_LOG2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    input  logic       enable,
    input  logic [1:0] sel,
    output logic       expired_o
);
    localparam int CW = MON_LOG2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          expired;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [CW-1:0] limit_m1;

    always_comb begin
        limit_m1 = '1 >> (2 * sel);
    end

    always_comb begin
        mon_d = mon_q;
        if (start) begin
            mon_d.cnt     = '0;
            mon_d.expired = 1'b0;
        end else if (run && !mon_q.expired) begin
            if (enable && (mon_q.cnt == limit_m1))
                mon_d.expired = 1'b1;
            else
                mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign expired_o = mon_q.expired;

    // R9: an expiry holds until the next cycle starts
    assert_expiry_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q.expired && !start) |=> mon_q.expired);

    // R10: a disabled watchdog never expires
    assert_no_expiry_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !mon_q.expired && !start) |=> !mon_q.expired);
endmodule

// File: rtl/btc_term_ctrl.sv
module btc_term_ctrl
    import btc_pkg::*;
#(
    parameter int  NUM_CS   = 4,
    parameter int  MON_LOG2 = 16,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cyc_req,
    input  logic [CS_W-1:0]        cs_sel,
    input  logic [NUM_CS-1:0]      cfg_auto,
    input  logic [WS_W*NUM_CS-1:0] cfg_wait,
    input  logic                   mon_en,
    input  logic [1:0]             mon_sel,
    input  logic                   ack_n,
    input  logic                   err_clr,
    output logic                   bus_tick,
    output logic                   done,
    output logic                   done_timeout,
    output logic                   err_sticky
);
    typedef struct packed {
        logic       phase;
        btc_state_e state;
        logic       auto_ack;
        logic       mon_on;
        logic [1:0] mon_code;
        logic       timeout;
        logic       err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            bus_en;
    logic            accept;
    logic            busy;
    logic            ack_sync;
    logic            wait_zero;
    logic            mon_exp;
    logic [WS_W-1:0] sel_wait;
    logic            set_err;

    assign bus_en = ctl_q.phase;
    assign busy   = (ctl_q.state == ST_BUSY);
    assign accept = bus_en && (ctl_q.state == ST_IDLE) && cyc_req;

    always_comb begin
        sel_wait = cfg_wait[cs_sel*WS_W +: WS_W];
    end

    btc_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_en  (bus_en),
        .ack_n_i (ack_n),
        .ack_o   (ack_sync)
    );

    btc_waitgen #(.CNT_W(WS_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .load     (accept),
        .load_val (sel_wait),
        .run      (busy),
        .zero_o   (wait_zero)
    );

    btc_monitor #(.MON_LOG2(MON_LOG2)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .run       (busy),
        .enable    (ctl_q.mon_on),
        .sel       (ctl_q.mon_code),
        .expired_o (mon_exp)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.phase = ~ctl_q.phase;
        set_err     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state    = ST_BUSY;
                    ctl_d.auto_ack = cfg_auto[cs_sel];
                    ctl_d.mon_on   = mon_en;
                    ctl_d.mon_code = mon_sel;
                    ctl_d.timeout  = 1'b0;
                end
            end
            ST_BUSY: begin
                if (bus_en) begin
                    if (ack_sync || (ctl_q.auto_ack && wait_zero)) begin
                        ctl_d.state   = ST_DONE;
                        ctl_d.timeout = 1'b0;
                    end else if (mon_exp) begin
                        ctl_d.state   = ST_DONE;
                        ctl_d.timeout = 1'b1;
                        set_err       = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (bus_en) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (err_clr) ctl_d.err = 1'b0;
        if (set_err) ctl_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_tick     = ctl_q.phase;
    assign done         = (ctl_q.state == ST_DONE);
    assign done_timeout = done && ctl_q.timeout;
    assign err_sticky   = ctl_q.err;

    // R7: completion never lasts beyond one bus clock
    assert_done_one_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |=> !done);

    // R7: completion changes only at bus edges
    assert_done_on_bus_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done != $past(done)) |-> $past(bus_tick));

    // R11: a watchdog ending is always recorded in the sticky bit
    assert_err_on_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_timeout |-> err_sticky);

    // R10: a watchdog ending needs the watchdog armed for this cycle
    assert_timeout_needs_mon_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_timeout) |-> ctl_q.mon_on);

    // R2: the bus tick never stays high on two system clocks in a row
    assert_tick_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |=> !bus_tick);
endmodule

// File: tb/btc_term_ctrl_test.sv
`timescale 1ns/1ps
module btc_term_ctrl_test;
    localparam int NCS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cyc_req = 1'b0;
    logic [1:0]     cs_sel = '0;
    logic [NCS-1:0] cfg_auto = '0;
    logic [4*NCS-1:0] cfg_wait = '0;
    logic           mon_en = 1'b1;
    logic [1:0]     mon_sel = 2'd0;
    logic           ack_n = 1'b1;
    logic           err_clr = 1'b0;
    logic           bus_tick, done, done_timeout, err_sticky;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    btc_term_ctrl #(.NUM_CS(NCS), .MON_LOG2(16)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cs_sel(cs_sel),
        .cfg_auto(cfg_auto), .cfg_wait(cfg_wait), .mon_en(mon_en),
        .mon_sel(mon_sel), .ack_n(ack_n), .err_clr(err_clr),
        .bus_tick(bus_tick), .done(done), .done_timeout(done_timeout),
        .err_sticky(err_sticky)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one cycle. Latency counts system edges after the accepting edge
    // (-1 when no completion within max_clk). ack_at: edge before which ack_n
    // falls (-1 none); glitch_at: odd edge covered by a one-clock low pulse.
    task automatic run_cycle(input int cs, input int ack_at, input int glitch_at,
                             input int max_clk, output int lat, output int to,
                             output int width);
        lat = -1; to = 0; width = 0;
        cs_sel = 2'(cs);
        @(negedge clk);
        while (!bus_tick) @(negedge clk);
        cyc_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_req = 1'b0;
        for (int t = 1; t <= max_clk; t++) begin
            if (t == ack_at) ack_n = 1'b0;
            if (t == glitch_at) ack_n = 1'b0;
            if (t == glitch_at + 1) ack_n = 1'b1;
            @(posedge clk);
            #1;
            if (done) begin
                lat = t;
                to = int'(done_timeout);
                break;
            end
            @(negedge clk);
        end
        if (lat >= 0) begin
            width = 1;
            for (int k = 0; k < 3; k++) begin
                @(posedge clk);
                #1;
                if (done) width++;
            end
        end
        ack_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int lat, to, w, n, exp;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", int'(done), 0);
        check("R1 done_timeout", int'(done_timeout), 0);
        check("R1 err_sticky", int'(err_sticky), 0);
        rst_n = 1'b1;
        // R2: bus tick alternates
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            n = int'(bus_tick);
            @(negedge clk);
            check("R2 bus_tick toggle", int'(bus_tick), 1 - n);
        end

        // R3 and R12: wait-state sweep over every chip select
        cfg_auto = '1;
        mon_sel = 2'd3;
        for (int c = 0; c < NCS; c++) begin
            for (int v = 0; v < 16; v++) begin
                for (int i = 0; i < NCS; i++) cfg_wait[4*i +: 4] = 4'((v + 3*i) % 16);
                n = (v + 3*c) % 16;
                run_cycle(c, -1, -1, 100, lat, to, w);
                check("R3/R12 wait latency", lat, 2*(n+1));
                check("R3 normal flag", to, 0);
                check("R7 pulse width", w, 2);
            end
        end
        check("R11 no err after normal endings", int'(err_sticky), 0);

        // R4: external acknowledge only
        cfg_auto = '0;
        for (int j = 1; j <= 6; j++) begin
            run_cycle(0, 2*j, -1, 200, lat, to, w);
            check("R4 ext latency", lat, 2*(j+2));
            check("R4 normal flag", to, 0);
        end

        // R8: a glitch covering no bus edge is ignored
        run_cycle(1, 30, 5, 200, lat, to, w);
        check("R8 glitch ignored", lat, 34);
        run_cycle(1, 40, 11, 200, lat, to, w);
        check("R8 glitch ignored late", lat, 44);

        // R5 and R6: race between the two sources, wait count 8
        cfg_auto = '1;
        for (int i = 0; i < NCS; i++) cfg_wait[4*i +: 4] = 4'd8;
        for (int j = 1; j <= 10; j++) begin
            run_cycle(2, 2*j, -1, 200, lat, to, w);
            exp = (9 < j + 2) ? 9 : j + 2;
            check("R5 race latency", lat, 2*exp);
            if (j == 7) check("R6 single pulse on tie", w, 2);
        end

        // R9 and R11: watchdog periods, short codes first
        cfg_auto = 4'b0101;
        mon_en = 1'b1;
        for (int code = 3; code >= 1; code--) begin
            mon_sel = 2'(code);
            run_cycle(1, -1, -1, 70000, lat, to, w);
            check("R9 timeout latency", lat, (1 << (16 - 2*code)) + 2);
            check("R9 timeout flag", to, 1);
            check("R11 err set", int'(err_sticky), 1);
        end
        // R11: a normal ending keeps the error set, then clear drops it
        run_cycle(0, -1, -1, 100, lat, to, w);
        check("R11 err held", int'(err_sticky), 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        check("R11 err cleared", int'(err_sticky), 0);

        // R10: watchdog disabled, only a late acknowledge ends the cycle
        mon_en = 1'b0;
        mon_sel = 2'd3;
        run_cycle(3, 3000, -1, 4000, lat, to, w);
        check("R10 no watchdog ending", lat, 3004);
        check("R10 normal flag", to, 0);
        check("R10 err still clear", int'(err_sticky), 0);

        // R9: reset-default period code
        mon_en = 1'b1;
        mon_sel = 2'd0;
        run_cycle(3, -1, -1, 70000, lat, to, w);
        check("R9 code0 latency", lat, 65538);
        check("R9 code0 flag", to, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule